// File: doc/BRIEF.md
# Banked Indirect Register Window

This block sits on the slave side of a 32-bit host bus. It opens a 256-word page onto a 21-bit register space held by a PCS. Each internal register address has two fields: a 5-bit device number in bits [20:16] and a 16-bit register number in bits [15:0]. The page cannot cover that whole space, so the top word of the page (word index 0xFF, byte offset 0x3FC) holds a bank selector. The bank selector supplies internal address bits [20:8]. Any other word index in the page supplies the low 8 bits of the internal address.

Software reaches a register in two steps. It first writes the bank number, which is the internal address shifted right by 8, into word 0xFF. It then reads or writes the word whose index equals the low 8 bits of that address. Register data is 16 bits wide and travels in bits [15:0] of the host word. Because word 0xFF always decodes to the bank selector, internal offset 0xFF cannot be reached in any bank.

Only two device numbers, 30 and 31, have registers behind them. An access to any other device never reaches the internal port. Such a read returns the fill value 0xFFFF. Such a write is discarded. In both cases a one-cycle error pulse is raised.

Top module: `banked_reg_window`

## Requirements
- R1: After reset the bank register is zero, and both `host_rvalid` and `host_err` are low. A read of word 0xFF made straight after reset returns 0x00000000.
- R2: A host write to word index 0xFF loads `host_wdata[12:0]` into the bank register and ignores bits [31:13]. A later read of word 0xFF returns the bank value zero-extended to 32 bits. The bank register changes only on such a write.
- R3: When an access is forwarded, `rf_addr` equals `{bank, host_widx}`. This places device number bank[12:8] in `rf_addr[20:16]` and register number `{bank[7:0], host_widx}` in `rf_addr[15:0]`.
- R4: A host write to a word other than 0xFF, while the bank selects device 30 or 31, raises `rf_req` with `rf_we`=1 in the same cycle. `rf_wdata` equals `host_wdata[15:0]`, and `host_wdata[31:16]` has no effect.
- R5: A host read of a word other than 0xFF, while the bank selects device 30 or 31, raises `rf_req` with `rf_we`=0 in the same cycle. In the next cycle, `host_rdata` equals `{16'h0000, rf_rdata}` sampled in the request cycle.
- R6: An access to word 0xFF never raises `rf_req`. As a result, `rf_addr[7:0]` is never 0xFF while `rf_req` is high.
- R7: A read of a word other than 0xFF, while the bank selects any device except 30 or 31, does not raise `rf_req`. It returns 0x0000FFFF in the next cycle, with `host_err` high for that one cycle.
- R8: A write of a word other than 0xFF, while the bank selects any device except 30 or 31, does not raise `rf_req` and changes no register. `host_err` is high for exactly the one cycle after the request.
- R9: `host_rvalid` is high for exactly the one cycle after each read request and is low at every other time. Write requests never raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| host_req | input | 1 | Single-cycle host access strobe |
| host_we | input | 1 | 1 = write, 0 = read |
| host_widx | input | 8 | Word index within the page (byte offset divided by 4) |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, valid while host_rvalid is high |
| host_rvalid | output | 1 | Read data valid, one cycle after a read request |
| host_err | output | 1 | One-cycle pulse after an access to a device with no registers behind it |
| rf_req | output | 1 | Internal register-file access strobe |
| rf_we | output | 1 | Internal write enable |
| rf_addr | output | 21 | Internal register address (device number, register number) |
| rf_wdata | output | 16 | Internal write data |
| rf_rdata | input | 16 | Internal read data, combinational from rf_addr |

## Verification
A wrong bank value shows up on the very first forwarded access after it. `rf_addr[20:8]` then differs from the bank the bench expects, or the access is forwarded, or not forwarded, contrary to the device decode. The same fault also shows on the next read of word 0xFF. A fault in the device decode or in the page-top decode appears in the same cycle as the request, as a wrong `rf_req`. It is also visible one cycle later as a wrong error pulse, wrong fill data, or wrong read-back data.

// File: rtl/win_pkg.sv
package win_pkg;

  typedef enum logic [1:0] {
    RSRC_NONE = 2'd0,
    RSRC_BANK = 2'd1,
    RSRC_RF   = 2'd2,
    RSRC_FILL = 2'd3
  } rsrc_e;

  typedef struct packed {
    logic  bank_wr;
    logic  fwd;
    logic  unbacked;
    rsrc_e src;
  } dec_t;

endpackage

// File: rtl/win_rst_sync.sv
module win_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_o = sync_q[1];

endmodule

// File: rtl/win_bank_reg.sv
module win_bank_reg #(
  parameter int BANK_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BANK_W-1:0] wr_val,
  output logic [BANK_W-1:0] bank_o
);

  logic [BANK_W-1:0] bank_d;
  logic [BANK_W-1:0] bank_q;

  always_comb begin
    bank_d = bank_q;
    if (wr_en) begin
      bank_d = wr_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= '0;
    end else begin
      bank_q <= bank_d;
    end
  end

  assign bank_o = bank_q;

endmodule

// File: rtl/win_decode.sv
module win_decode
  import win_pkg::*;
#(
  parameter int                      OFS_W    = 8,
  parameter int                      BANK_W   = 13,
  parameter int                      DEV_W    = 5,
  parameter int                      NUM_DEV  = 2,
  parameter logic [NUM_DEV*DEV_W-1:0] DEV_LIST = {5'd31, 5'd30}
) (
  input  logic              req,
  input  logic              we,
  input  logic [OFS_W-1:0]  ofs,
  input  logic [BANK_W-1:0] bank,
  output dec_t              dec_o
);

  logic [DEV_W-1:0]   dev;
  logic [NUM_DEV-1:0] hit;
  logic               is_sel;
  logic               backed;

  assign dev    = bank[BANK_W-1 -: DEV_W];
  assign is_sel = &ofs;

  for (genvar i = 0; i < NUM_DEV; i++) begin : g_dev_cmp
    assign hit[i] = (dev == DEV_LIST[i*DEV_W +: DEV_W]);
  end

  assign backed = |hit;

  always_comb begin
    dec_o.bank_wr  = req & we & is_sel;
    dec_o.fwd      = req & ~is_sel & backed;
    dec_o.unbacked = req & ~is_sel & ~backed;
    if (is_sel) begin
      dec_o.src = RSRC_BANK;
    end else if (backed) begin
      dec_o.src = RSRC_RF;
    end else begin
      dec_o.src = RSRC_FILL;
    end
  end

endmodule

// File: rtl/win_resp.sv
module win_resp
  import win_pkg::*;
#(
  parameter int HOST_W = 32,
  parameter int DATA_W = 16,
  parameter int BANK_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  rsrc_e             src,
  input  logic              unbacked,
  input  logic [BANK_W-1:0] bank,
  input  logic [DATA_W-1:0] rf_rdata,
  output logic [HOST_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic              err_o
);

  logic [HOST_W-1:0] rdata_d, rdata_q;
  logic              rvalid_d, rvalid_q;
  logic              err_d, err_q;
  logic              rd_en;

  assign rd_en = req & ~we;

  always_comb begin
    rvalid_d = rd_en;
    err_d    = unbacked;
    rdata_d  = rdata_q;
    if (rd_en) begin
      case (src)
        RSRC_BANK: rdata_d = {{(HOST_W-BANK_W){1'b0}}, bank};
        RSRC_RF:   rdata_d = {{(HOST_W-DATA_W){1'b0}}, rf_rdata};
        RSRC_FILL: rdata_d = {{(HOST_W-DATA_W){1'b0}}, {DATA_W{1'b1}}};
        default:   rdata_d = rdata_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      rdata_q  <= rdata_d;
      rvalid_q <= rvalid_d;
      err_q    <= err_d;
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;
  assign err_o    = err_q;

endmodule

// File: rtl/banked_reg_window.sv
module banked_reg_window
  import win_pkg::*;
#(
  parameter int                      HOST_W   = 32,
  parameter int                      DATA_W   = 16,
  parameter int                      DEV_W    = 5,
  parameter int                      REGN_W   = 16,
  parameter int                      OFS_W    = 8,
  parameter int                      NUM_DEV  = 2,
  parameter logic [NUM_DEV*DEV_W-1:0] DEV_LIST = {5'd31, 5'd30},
  localparam int                     ADDR_W   = DEV_W + REGN_W,
  localparam int                     BANK_W   = ADDR_W - OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [OFS_W-1:0]  host_widx,
  input  logic [HOST_W-1:0] host_wdata,
  output logic [HOST_W-1:0] host_rdata,
  output logic              host_rvalid,
  output logic              host_err,
  output logic              rf_req,
  output logic              rf_we,
  output logic [ADDR_W-1:0] rf_addr,
  output logic [DATA_W-1:0] rf_wdata,
  input  logic [DATA_W-1:0] rf_rdata
);

  logic              rst_sync_n;
  logic [BANK_W-1:0] bank_q;
  dec_t              dec;
  logic              unused_hi;

  assign unused_hi = ^host_wdata[HOST_W-1:DATA_W];

  win_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_sync_n)
  );

  win_bank_reg #(.BANK_W(BANK_W)) u_bank (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .wr_en  (dec.bank_wr),
    .wr_val (host_wdata[BANK_W-1:0]),
    .bank_o (bank_q)
  );

  win_decode #(
    .OFS_W    (OFS_W),
    .BANK_W   (BANK_W),
    .DEV_W    (DEV_W),
    .NUM_DEV  (NUM_DEV),
    .DEV_LIST (DEV_LIST)
  ) u_dec (
    .req   (host_req),
    .we    (host_we),
    .ofs   (host_widx),
    .bank  (bank_q),
    .dec_o (dec)
  );

  win_resp #(
    .HOST_W (HOST_W),
    .DATA_W (DATA_W),
    .BANK_W (BANK_W)
  ) u_resp (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .req      (host_req),
    .we       (host_we),
    .src      (dec.src),
    .unbacked (dec.unbacked),
    .bank     (bank_q),
    .rf_rdata (rf_rdata),
    .rdata_o  (host_rdata),
    .rvalid_o (host_rvalid),
    .err_o    (host_err)
  );

  assign rf_req   = dec.fwd;
  assign rf_we    = host_we;
  assign rf_addr  = {bank_q, host_widx};
  assign rf_wdata = host_wdata[DATA_W-1:0];

endmodule

// File: rtl/win_checker.sv
module win_checker #(
  parameter int HOST_W = 32,
  parameter int ADDR_W = 21,
  parameter int BANK_W = 13,
  parameter int OFS_W  = 8
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              host_req,
  input logic              host_we,
  input logic [OFS_W-1:0]  host_widx,
  input logic [HOST_W-1:0] host_rdata,
  input logic              host_rvalid,
  input logic              host_err,
  input logic              rf_req,
  input logic              rf_we,
  input logic [ADDR_W-1:0] rf_addr,
  input logic [BANK_W-1:0] bank_q
);

  AST_SEL_NOT_FWD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (host_req && (&host_widx)) |-> !rf_req); // R6

  AST_RF_OFS_NOT_TOP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rf_req |-> !(&rf_addr[OFS_W-1:0])); // R6

  AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (host_req && !host_we) |=> host_rvalid); // R9

  AST_NO_SPURIOUS_RVALID: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(host_req && !host_we) |=> !host_rvalid); // R9

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    host_rvalid |-> (host_rdata[HOST_W-1:16] == '0)); // R5

  AST_ERR_READ_FILL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (host_rvalid && host_err) |-> (host_rdata == 32'h0000_FFFF)); // R7

  AST_DROP_FLAGS_ERR: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (host_req && !(&host_widx) && !rf_req) |=> host_err); // R8

  AST_NO_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !host_req |=> !host_err); // R8

  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(host_req && host_we && (&host_widx)) |=> $stable(bank_q)); // R2

  AST_RF_DIR: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rf_req |-> (rf_we == host_we)); // R4

endmodule

bind banked_reg_window win_checker #(
  .HOST_W (HOST_W),
  .ADDR_W (ADDR_W),
  .BANK_W (BANK_W),
  .OFS_W  (OFS_W)
) chk_i (
  .clk         (clk),
  .rst_sync_n  (rst_sync_n),
  .host_req    (host_req),
  .host_we     (host_we),
  .host_widx   (host_widx),
  .host_rdata  (host_rdata),
  .host_rvalid (host_rvalid),
  .host_err    (host_err),
  .rf_req      (rf_req),
  .rf_we       (rf_we),
  .rf_addr     (rf_addr),
  .bank_q      (bank_q)
);

// File: tb/banked_reg_window_tb_top.sv
`timescale 1ns/1ps
module banked_reg_window_tb_top;

  logic        clk;
  logic        rst_n;
  logic        host_req;
  logic        host_we;
  logic [7:0]  host_widx;
  logic [31:0] host_wdata;
  logic [31:0] host_rdata;
  logic        host_rvalid;
  logic        host_err;
  logic        rf_req;
  logic        rf_we;
  logic [20:0] rf_addr;
  logic [15:0] rf_wdata;
  logic [15:0] rf_rdata;

  int total;
  int bad;

  logic [15:0] rfmem  [128];
  logic [15:0] m_mem  [128];
  logic [12:0] m_bank;

  banked_reg_window dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_req    (host_req),
    .host_we     (host_we),
    .host_widx   (host_widx),
    .host_wdata  (host_wdata),
    .host_rdata  (host_rdata),
    .host_rvalid (host_rvalid),
    .host_err    (host_err),
    .rf_req      (rf_req),
    .rf_we       (rf_we),
    .rf_addr     (rf_addr),
    .rf_wdata    (rf_wdata),
    .rf_rdata    (rf_rdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  assign rf_rdata = rfmem[{rf_addr[16], rf_addr[5:0]}];

  always @(posedge clk) begin
    if (rf_req && rf_we) rfmem[{rf_addr[16], rf_addr[5:0]}] <= rf_wdata;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic access(input bit we, input logic [7:0] ofs, input logic [31:0] wd,
                        input string tag);
    bit          sel;
    bit          backed;
    bit          fwd;
    int          dev;
    int          idx;
    logic [31:0] exp_rd;
    sel    = (ofs == 8'hFF);
    dev    = int'(m_bank >> 8);
    backed = (dev == 30) || (dev == 31);
    fwd    = !sel && backed;
    idx    = {m_bank[8], ofs[5:0]};
    if (sel)         exp_rd = {19'd0, m_bank};
    else if (backed) exp_rd = {16'd0, m_mem[idx]};
    else             exp_rd = 32'h0000_FFFF;
    @(negedge clk);
    host_req   = 1'b1;
    host_we    = we;
    host_widx  = ofs;
    host_wdata = wd;
    #1;
    chk({tag, " rf_req"}, {31'd0, rf_req}, {31'd0, fwd});
    if (fwd) begin
      chk({tag, " rf_we"}, {31'd0, rf_we}, {31'd0, we});
      chk({tag, " R3 rf_addr"}, {11'd0, rf_addr}, {11'd0, m_bank, ofs});
      if (we) chk({tag, " rf_wdata"}, {16'd0, rf_wdata}, {16'd0, wd[15:0]});
    end
    @(negedge clk);
    host_req = 1'b0;
    host_we  = 1'b0;
    #1;
    chk({tag, " R9 rvalid"}, {31'd0, host_rvalid}, {31'd0, !we});
    chk({tag, " err"}, {31'd0, host_err}, {31'd0, (!sel && !backed)});
    if (!we) chk({tag, " rdata"}, host_rdata, exp_rd);
    if (we && sel) m_bank = wd[12:0];
    if (we && fwd) m_mem[idx] = wd[15:0];
    @(negedge clk);
    #1;
    chk({tag, " R9 idle rvalid"}, {31'd0, host_rvalid}, 32'd0);
    chk({tag, " R8 idle err"}, {31'd0, host_err}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    total = 0;
    bad   = 0;
    for (int i = 0; i < 128; i++) begin
      rfmem[i] = 16'h4000 + 16'(i) * 16'h0123;
      m_mem[i] = 16'h4000 + 16'(i) * 16'h0123;
    end
    m_bank     = '0;
    host_req   = 1'b0;
    host_we    = 1'b0;
    host_widx  = '0;
    host_wdata = '0;
    rst_n      = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk("R1 reset rvalid", {31'd0, host_rvalid}, 32'd0);
    chk("R1 reset err", {31'd0, host_err}, 32'd0);
    access(1'b0, 8'hFF, 32'h0, "R1 bank read after reset");

    access(1'b0, 8'h10, 32'h0, "R7 read unbacked dev0");
    access(1'b1, 8'h10, 32'h0000_5555, "R8 write unbacked dev0");

    access(1'b1, 8'hFF, 32'hFFFF_FE05, "R2 bank write upper ignored");
    access(1'b0, 8'hFF, 32'h0, "R2 bank readback");

    access(1'b0, 8'h10, 32'h0, "R5 read dev30 before write");
    access(1'b1, 8'h10, 32'hABCD_1234, "R4 write dev30");
    access(1'b0, 8'h10, 32'h0, "R5 read dev30 after write");
    access(1'b0, 8'h11, 32'h0, "R5 read dev30 neighbour");
    access(1'b0, 8'hFE, 32'h0, "R3 read offset FE");

    access(1'b0, 8'hFF, 32'h0, "R6 read page top");
    access(1'b1, 8'hFF, 32'h0000_1FFE, "R6 write page top");
    access(1'b1, 8'h00, 32'h7777_BEEF, "R4 write dev31 offset 0");
    access(1'b0, 8'h00, 32'h0, "R5 read dev31 offset 0");
    access(1'b1, 8'hFE, 32'h0000_0042, "R4 write dev31 offset FE");
    access(1'b0, 8'hFE, 32'h0, "R5 read dev31 offset FE");

    access(1'b1, 8'hFF, 32'h0000_1D00, "R2 bank dev29");
    access(1'b1, 8'h00, 32'h0000_9999, "R8 write unbacked dev29");
    access(1'b0, 8'h00, 32'h0, "R7 read unbacked dev29");

    access(1'b1, 8'hFF, 32'h0000_1F00, "R2 bank dev31 again");
    access(1'b0, 8'h00, 32'h0, "R8 dropped write left dev31 intact");
    access(1'b1, 8'hFF, 32'h0000_1E05, "R2 bank dev30 again");
    access(1'b0, 8'h10, 32'h0, "R4 dev30 data kept");

    finish_run();
  end

endmodule